// File: doc/BRIEF.md
# Dual Reload/Capture Timer with Paired PWM and 64-bit Chaining

The block holds two identical timer channels, each with a control/status word, a reload value and a running count. Software reaches all three words over a plain 32-bit word-aligned write/read port. A running channel counts up or down from its reload value. When it reaches its terminal count it either reloads and carries on or halts. That terminal event raises a pending flag and sends a one-cycle pulse on the channel's generate output. A channel set to capture mode instead watches its own external capture pin. The pin is synchronised, and on the selected edge the live count is copied into the reload word.

The two channels can also work as a pair. In PWM pairing, channel 0 sets the period and channel 1 sets the high time. Each channel-0 terminal event drives the PWM line high and restarts channel 1. A channel-1 terminal event drives the line low. In chained mode the channels form one 64-bit up/down counter, with channel 1 as the upper half. A start-both bit sets both run bits on the same clock edge, so paired channels stay in step.

Top module: `dtmr_core`

## Requirements
- R1: After reset every register reads zero and gen_out, pwm_out and irq are low.
- R2: A channel whose run bit (bit 6) is set and whose load bit (bit 4) is clear changes its count by one per clock: down when bit 1 of its control word is set, up otherwise.
- R3: The terminal count is all-ones when counting up and zero when counting down. The next tick after it is a carry. If auto-reload (bit 2) is set, the carry loads the reload word. If it is clear, the count holds at the terminal value and the run bit clears.
- R4: While the load bit is set, the count equals the reload word. The copy appears one cycle after the bit is written, and the count does not move.
- R5: A carry in generate mode or a capture event sets the pending bit (bit 7). Writing 1 to bit 7 clears it, and writing 0 leaves it unchanged. irq is high when any channel has both its pending bit and its interrupt-enable bit (bit 5) set.
- R6: Each generate-mode carry produces a one-clock pulse on that channel's gen_out bit. With an up-counting auto-reload value L, the pulses repeat every (2^32 - L) cycles.
- R7: With capture mode (bit 0) and run set, an edge on cap_in passes through two sync flops and an edge detector. The edge copies the count into the reload word and sets pending. Bit 3 clear selects the rising edge and bit 3 set selects the falling edge. The other edge has no effect.
- R8: With PWM pairing (channel-0 bit 9) set, pwm_out goes high on the start-both write and on each channel-0 carry, and that carry reloads channel 1. A channel-1 carry drives pwm_out low. With down-counting reload values P and H, pwm_out is high for H+1 of every P+1 cycles.
- R9: In PWM pairing, if the high time is not shorter than the period, pwm_out stays high.
- R10: With chaining (channel-0 bit 10) set, channel 1 steps only on a channel-0 carry, in channel 0's direction. The 64-bit terminal event applies channel 0's auto-reload or stop to both halves and sets channel 0's pending bit.
- R11: Writing 1 to bit 8 of channel 0's control word sets both run bits on the same edge. Bit 8 reads back as zero.
- R12: Word addresses: channel select is address bit 4, and address bits 3:2 select control (0), reload (1) or count (2). Writes need address bits 1:0 to be zero. Control bits 0 to 7 read back as written, except that bit 7 shows the pending flag. Bits 9 and 10 of channel 0 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cap_in | input | 2 | Asynchronous capture inputs, one per channel |
| gen_out | output | 2 | One-cycle carry pulse per channel |
| pwm_out | output | 1 | Paired PWM waveform |
| irq | output | 1 | Combined interrupt request |

## Verification
The checker watches channel 0 on every cycle. It covers the single step per tick, the count being pinned to the reload word while loading, the halt at terminal count without reload, and pending being cleared by a write of 1. It also checks that the upper half stays still between lower-half carries when chained, and that pwm_out falls after a high-time carry. Exact periods, duty ratios, the synchroniser latency of a capture, the start-both lockstep and the long-word carry into both halves depend on multi-cycle sequences. Only the bench's scenarios, with expected counts worked out from the register values, can show those.

// File: rtl/dtmr_pkg.sv
// Package: shared control-word layout and register selectors for the dual timer.
// Assumes a 32-bit control word; bits 0..7 live in each channel, 8..10 in channel 0 only.
package dtmr_pkg;
    localparam int B_CAPT  = 0;
    localparam int B_DOWN  = 1;
    localparam int B_ARLD  = 2;
    localparam int B_CPOL  = 3;
    localparam int B_LOAD  = 4;
    localparam int B_IEN   = 5;
    localparam int B_RUN   = 6;
    localparam int B_PEND  = 7;
    localparam int B_GOALL = 8;
    localparam int B_PWM   = 9;
    localparam int B_CASC  = 10;

    localparam logic [1:0] SEL_CTL = 2'd0;
    localparam logic [1:0] SEL_RLD = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;

    // Packed so that field positions equal the bit numbers above (pend is bit 7).
    typedef struct packed {
        logic pend;
        logic run;
        logic ien;
        logic ld;
        logic cpol;
        logic arld;
        logic down;
        logic capt;
    } chctl_t;
endpackage

// File: rtl/dtmr_capsync.sv
// Module: dtmr_capsync
// Brings an asynchronous capture pin into the clock domain through STAGES flops.
// Then it flags the selected edge for one cycle.
// Assumes the pin is slow relative to clk; a glitch shorter than a cycle may be missed.
module dtmr_capsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_hit
);
    logic [STAGES:0] sh;

    // Purpose: shift the pin through the sync stages plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], pin};
    end

    // Purpose: pick the rising or falling transition of the synchronised level.
    always_comb begin
        if (fall_sel) edge_hit = ~sh[STAGES-1] &  sh[STAGES];
        else          edge_hit =  sh[STAGES-1] & ~sh[STAGES];
    end
endmodule

// File: rtl/dtmr_chan.sv
// Module: dtmr_chan
// One timer channel: control/status word, reload word, counter, terminal-event logic and capture.
// Assumes the top decodes bus writes.
// When slave is high the channel is the upper half of a chained pair:
// it steps on step_in, uses dir_ext, and never raises its own event.
module dtmr_chan
    import dtmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctl,
    input  logic         wr_rld,
    input  logic [W-1:0] wdata,
    input  logic         go,
    input  logic         slave,
    input  logic         step_in,
    input  logic         dir_ext,
    input  logic         carry_ok,
    input  logic         restart,
    input  logic         cap_evt,
    output chctl_t       ctl,
    output logic [W-1:0] rld_q,
    output logic [W-1:0] cnt_q,
    output logic         at_tc,
    output logic         carry,
    output logic         evt,
    output logic         gen
);
    logic         down_eff;
    logic         tick;
    logic         cap_hit;
    logic [W-1:0] nxt;

    // Purpose: derive direction, terminal detection, tick and event strobes.
    always_comb begin
        down_eff = slave ? dir_ext : ctl.down;
        at_tc    = down_eff ? (cnt_q == '0) : (cnt_q == '1);
        tick     = slave ? step_in : (ctl.run & ~ctl.ld);
        carry    = tick & at_tc;
        evt      = carry & carry_ok & ~ctl.capt & ~slave;
        cap_hit  = ctl.capt & ctl.run & cap_evt & ~slave;
        nxt      = down_eff ? cnt_q - W'(1) : cnt_q + W'(1);
    end

    // Purpose: control/status word with start-both, halt-on-carry and write-1-to-clear pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else begin
            if (wr_ctl) begin
                ctl.capt <= wdata[B_CAPT];
                ctl.down <= wdata[B_DOWN];
                ctl.arld <= wdata[B_ARLD];
                ctl.cpol <= wdata[B_CPOL];
                ctl.ld   <= wdata[B_LOAD];
                ctl.ien  <= wdata[B_IEN];
                ctl.run  <= wdata[B_RUN] | go;
                ctl.pend <= ctl.pend & ~wdata[B_PEND];
            end else if (go) begin
                ctl.run <= 1'b1;
            end
            if (evt && !ctl.arld) ctl.run  <= 1'b0;
            if (evt || cap_hit)   ctl.pend <= 1'b1;
        end
    end

    // Purpose: reload word, written by the bus or by a capture event.
    always_ff @(posedge clk) begin
        if (!rst_n)       rld_q <= '0;
        else if (wr_rld)  rld_q <= wdata;
        else if (cap_hit) rld_q <= cnt_q;
    end

    // Purpose: counter with load hold, external restart, reload-or-halt on event, else step.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (ctl.ld || restart)   cnt_q <= rld_q;
        else if (evt) begin
            if (ctl.arld)             cnt_q <= rld_q;
        end
        else if (tick)                cnt_q <= nxt;
    end

    // Purpose: one-cycle generate pulse per terminal event.
    always_ff @(posedge clk) begin
        if (!rst_n) gen <= 1'b0;
        else        gen <= evt;
    end
endmodule

// File: rtl/dtmr_pwm.sv
// Module: dtmr_pwm
// Builds the paired PWM level: set on start or period event, cleared on high-time event.
// Set wins when both events meet. Assumes en is the registered pairing bit.
// start is the start-both write that also turns pairing on, so it may precede en by one edge.
module dtmr_pwm (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic set_evt,
    input  logic clr_evt,
    output logic pwm
);
    logic q;

    // Purpose: hold the PWM level between period and high-time events.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (start)   q <= 1'b1;
        else if (!en)     q <= 1'b0;
        else if (set_evt) q <= 1'b1;
        else if (clr_evt) q <= 1'b0;
    end

    assign pwm = q & en;
endmodule

// File: rtl/dtmr_core.sv
// Module: dtmr_core (top)
// Two timer channels behind a word-aligned register port, with PWM pairing and 64-bit chaining.
// Assumes a single clock, one-cycle write strobes, reads decoded combinationally, and W >= 11.
module dtmr_core
    import dtmr_pkg::*;
#(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic [4:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [1:0]   cap_in,
    output logic [1:0]   gen_out,
    output logic         pwm_out,
    output logic         irq
);
    localparam int NCH = 2;

    chctl_t         ctl_q [NCH];
    logic [W-1:0]   rld_q [NCH];
    logic [W-1:0]   cnt_q [NCH];
    logic [NCH-1:0] wr_ctl, wr_rld, cap_evt, at_tc_v, carry_v, evt_v, gen_v;
    logic [NCH-1:0] slave_v, step_v, dir_v, cok_v, rst_v;
    logic [NCH-1:0] run_v, ld_v, capt_v, arld_v, down_v, pend_v, ien_v;
    logic           pwm_en, cascade, go_all;
    logic           ch_sel;
    logic [1:0]     reg_sel;

    assign ch_sel  = bus_addr[4];
    assign reg_sel = bus_addr[3:2];
    assign go_all  = wr_ctl[0] & bus_wdata[B_GOALL];

    // Purpose: decode word-aligned writes to each channel's registers.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            wr_ctl[i] = bus_we && (bus_addr[1:0] == 2'b00) && (ch_sel == i[0]) && (reg_sel == SEL_CTL);
            wr_rld[i] = bus_we && (bus_addr[1:0] == 2'b00) && (ch_sel == i[0]) && (reg_sel == SEL_RLD);
        end
    end

    // Purpose: pairing mode bits, held in channel 0's control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_en  <= 1'b0;
            cascade <= 1'b0;
        end else if (wr_ctl[0]) begin
            pwm_en  <= bus_wdata[B_PWM];
            cascade <= bus_wdata[B_CASC];
        end
    end

    // Purpose: cross-channel links for chaining and PWM restart.
    always_comb begin
        slave_v = {cascade, 1'b0};
        step_v  = {carry_v[0] & ~evt_v[0], 1'b0};
        dir_v   = {ctl_q[0].down, 1'b0};
        cok_v   = {1'b1, cascade ? at_tc_v[1] : 1'b1};
        rst_v   = {(pwm_en & evt_v[0]) | (cascade & evt_v[0] & ctl_q[0].arld), 1'b0};
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            dtmr_capsync #(.STAGES(STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin      (cap_in[g]),
                .fall_sel (ctl_q[g].cpol),
                .edge_hit (cap_evt[g])
            );

            dtmr_chan #(.W(W)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_ctl   (wr_ctl[g]),
                .wr_rld   (wr_rld[g]),
                .wdata    (bus_wdata),
                .go       (go_all),
                .slave    (slave_v[g]),
                .step_in  (step_v[g]),
                .dir_ext  (dir_v[g]),
                .carry_ok (cok_v[g]),
                .restart  (rst_v[g]),
                .cap_evt  (cap_evt[g]),
                .ctl      (ctl_q[g]),
                .rld_q    (rld_q[g]),
                .cnt_q    (cnt_q[g]),
                .at_tc    (at_tc_v[g]),
                .carry    (carry_v[g]),
                .evt      (evt_v[g]),
                .gen      (gen_v[g])
            );

            assign run_v[g]  = ctl_q[g].run;
            assign ld_v[g]   = ctl_q[g].ld;
            assign capt_v[g] = ctl_q[g].capt;
            assign arld_v[g] = ctl_q[g].arld;
            assign down_v[g] = ctl_q[g].down;
            assign pend_v[g] = ctl_q[g].pend;
            assign ien_v[g]  = ctl_q[g].ien;
        end
    endgenerate

    dtmr_pwm u_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (pwm_en),
        .start   (go_all & bus_wdata[B_PWM]),
        .set_evt (evt_v[0]),
        .clr_evt (evt_v[1]),
        .pwm     (pwm_out)
    );

    // Purpose: combinational read mux over the selected channel's words.
    always_comb begin
        bus_rdata = '0;
        case (reg_sel)
            SEL_CTL: begin
                bus_rdata[7:0] = ctl_q[ch_sel];
                if (!ch_sel) begin
                    bus_rdata[B_PWM]  = pwm_en;
                    bus_rdata[B_CASC] = cascade;
                end
            end
            SEL_RLD: bus_rdata = rld_q[ch_sel];
            SEL_CNT: bus_rdata = cnt_q[ch_sel];
            default: bus_rdata = '0;
        endcase
    end

    assign gen_out = gen_v;
    assign irq     = |(pend_v & ien_v);
endmodule

// File: rtl/dtmr_core_chk.sv
// Module: dtmr_core_chk
// Clocked properties on channel 0 and the pairing logic, bound into dtmr_core.
// Assumes the signal meanings of dtmr_core; it only observes.
module dtmr_core_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_ctl0,
    input logic [W-1:0] bus_wdata,
    input logic         run0,
    input logic         ld0,
    input logic         capt0,
    input logic         arld0,
    input logic         down0,
    input logic         pend0,
    input logic         at_tc0,
    input logic         evt0,
    input logic         evt1,
    input logic         ld1,
    input logic         cascade,
    input logic         pwm_en,
    input logic         go_all,
    input logic [W-1:0] cnt0,
    input logic [W-1:0] cnt1,
    input logic [W-1:0] rld0,
    input logic         pwm_out
);
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run0 && !ld0 && !capt0 && !at_tc0) |=> (cnt0 == ($past(down0) ? $past(cnt0) - W'(1) : $past(cnt0) + W'(1)))); // R2

    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (run0 && !ld0 && !capt0 && at_tc0 && !arld0 && !cascade && !wr_ctl0) |=> (!run0 && $stable(cnt0))); // R3

    AST_LOAD_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        ld0 |=> (cnt0 == $past(rld0))); // R4

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl0 && bus_wdata[7] && !evt0 && !capt0) |=> !pend0); // R5

    AST_PWM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && evt1 && !evt0 && !go_all && !wr_ctl0) |=> !pwm_out); // R8

    AST_UPPER_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && !ld1 && !(run0 && !ld0 && at_tc0)) |=> $stable(cnt1)); // R10
endmodule

bind dtmr_core dtmr_core_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctl0   (wr_ctl[0]),
    .bus_wdata (bus_wdata),
    .run0      (run_v[0]),
    .ld0       (ld_v[0]),
    .capt0     (capt_v[0]),
    .arld0     (arld_v[0]),
    .down0     (down_v[0]),
    .pend0     (pend_v[0]),
    .at_tc0    (at_tc_v[0]),
    .evt0      (evt_v[0]),
    .evt1      (evt_v[1]),
    .ld1       (ld_v[1]),
    .cascade   (cascade),
    .pwm_en    (pwm_en),
    .go_all    (go_all),
    .cnt0      (cnt_q[0]),
    .cnt1      (cnt_q[1]),
    .rld0      (rld_q[0]),
    .pwm_out   (pwm_out)
);

// File: tb/dtmr_core_test.sv
// Bench for dtmr_core: a vector table of single-channel count runs, then directed scenarios.
module dtmr_core_test;
    localparam int W = 32;
    localparam logic [31:0] C_CAPT = 32'h001, C_DOWN = 32'h002, C_ARLD = 32'h004, C_CPOL = 32'h008;
    localparam logic [31:0] C_LOAD = 32'h010, C_IEN  = 32'h020, C_RUN  = 32'h040, C_PEND = 32'h080;
    localparam logic [31:0] C_GO   = 32'h100, C_PWM  = 32'h200, C_CASC = 32'h400;
    localparam logic [4:0]  A_CTL0 = 5'h00, A_RLD0 = 5'h04, A_CNT0 = 5'h08;
    localparam logic [4:0]  A_CTL1 = 5'h10, A_RLD1 = 5'h14, A_CNT1 = 5'h18;

    typedef struct packed {
        logic        ch;
        logic        dn;
        logic        rl;
        logic [31:0] ld;
        logic [7:0]  n;
        logic [31:0] exp_cnt;
        logic        exp_pend;
    } vec_t;

    localparam vec_t VT [6] = '{
        '{1'b0, 1'b0, 1'b1, 32'h0000_0010, 8'd5, 32'h0000_0015, 1'b0},
        '{1'b1, 1'b1, 1'b1, 32'h0000_0010, 8'd5, 32'h0000_000B, 1'b0},
        '{1'b0, 1'b0, 1'b1, 32'hFFFF_FFFC, 8'd6, 32'hFFFF_FFFE, 1'b1},
        '{1'b1, 1'b0, 1'b0, 32'hFFFF_FFFC, 8'd6, 32'hFFFF_FFFF, 1'b1},
        '{1'b0, 1'b1, 1'b1, 32'h0000_0003, 8'd5, 32'h0000_0002, 1'b1},
        '{1'b1, 1'b1, 1'b0, 32'h0000_0002, 8'd8, 32'h0000_0000, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [1:0]   cap_in = '0;
    logic [1:0]   gen_out;
    logic         pwm_out;
    logic         irq;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    dtmr_core #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
        .gen_out(gen_out), .pwm_out(pwm_out), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write takes effect at the next posedge; returns at the following negedge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        bad++; total++;
        $display("FAIL watchdog: act=timeout exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] v, w;
        int hi, pulses;
        logic [4:0] b, o;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values
        rd(A_CTL0, v); chk("R1 ctl0", v, 0);
        rd(A_RLD0, v); chk("R1 rld0", v, 0);
        rd(A_CNT0, v); chk("R1 cnt0", v, 0);
        rd(A_CTL1, v); chk("R1 ctl1", v, 0);
        rd(A_CNT1, v); chk("R1 cnt1", v, 0);
        chk("R1 outputs", {29'd0, gen_out, pwm_out}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_CTL0, v); chk("R1 ctl0 after release", v, 0);

        // Vector table: R2 step direction, R3 terminal handling, R5 pending and irq
        foreach (VT[i]) begin
            b = VT[i].ch ? 5'h10 : 5'h00;
            o = VT[i].ch ? 5'h00 : 5'h10;
            wr(o, C_PEND);
            wr(b | 5'h04, VT[i].ld);
            wr(b, C_LOAD | C_PEND);
            wr(b, C_RUN | C_IEN | (VT[i].dn ? C_DOWN : 0) | (VT[i].rl ? C_ARLD : 0));
            ticks(int'(VT[i].n));
            rd(b | 5'h08, v);
            chk($sformatf("R2/R3 vec%0d count", i), v, VT[i].exp_cnt);
            rd(b, v);
            chk($sformatf("R5 vec%0d pending", i), {31'd0, v[7]}, {31'd0, VT[i].exp_pend});
            chk($sformatf("R5 vec%0d irq", i), {31'd0, irq}, {31'd0, VT[i].exp_pend});
            if (!VT[i].rl && VT[i].exp_pend)
                chk($sformatf("R3 vec%0d run cleared", i), {31'd0, v[6]}, 0);
        end
        wr(A_CTL0, C_PEND); wr(A_CTL1, C_PEND);

        // R12 control readback, start-both reads zero
        wr(A_CTL0, C_DOWN | C_ARLD | C_CPOL | C_LOAD | C_IEN | C_RUN | C_PWM | C_CASC | C_GO);
        rd(A_CTL0, v);
        chk("R12 ctl0 readback", v, C_DOWN | C_ARLD | C_CPOL | C_LOAD | C_IEN | C_RUN | C_PWM | C_CASC);
        wr(A_CTL0, 0); wr(A_CTL1, 0);

        // R4 load bit pins the count even with run set
        wr(A_RLD0, 32'h77);
        wr(A_CTL0, C_LOAD | C_RUN);
        ticks(5);
        rd(A_CNT0, v); chk("R4 load hold", v, 32'h77);
        wr(A_CTL0, 0);

        // R6 generate pulses, period 2^32 - L = 4
        wr(A_RLD0, 32'hFFFF_FFFC);
        wr(A_CTL0, C_LOAD | C_PEND);
        wr(A_CTL0, C_RUN | C_ARLD);
        pulses = 0;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); @(negedge clk);
            pulses += int'(gen_out[0]);
            if (gen_out[1]) pulses += 100;
        end
        chk("R6 pulse count", pulses, 5);
        chk("R5 irq masked with pending", {31'd0, irq}, 0);
        wr(A_CTL0, C_PEND);
        rd(A_CTL0, v); chk("R5 w1c clears", {31'd0, v[7]}, 0);

        // R5 writing 0 to pending leaves it set
        wr(A_RLD1, 32'h1);
        wr(A_CTL1, C_LOAD | C_PEND);
        wr(A_CTL1, C_RUN | C_DOWN);
        ticks(4);
        wr(A_CTL1, C_IEN);
        rd(A_CTL1, v); chk("R5 write 0 keeps pending", {31'd0, v[7]}, 1);
        chk("R5 irq raised", {31'd0, irq}, 1);
        wr(A_CTL1, C_PEND);
        chk("R5 irq dropped", {31'd0, irq}, 0);

        // R7 rising-edge capture on channel 1
        wr(A_RLD1, 32'h100);
        wr(A_CTL1, C_LOAD);
        wr(A_CTL1, C_CAPT | C_RUN | C_IEN);
        ticks(3);
        cap_in[1] = 1'b1;
        ticks(1);
        ticks(1);
        rd(A_CNT1, w);
        ticks(1);
        rd(A_RLD1, v); chk("R7 rising capture value", v, w);
        rd(A_CTL1, v); chk("R7 capture pending", {31'd0, v[7]}, 1);
        wr(A_CTL1, C_PEND);

        // R7 falling-edge select: rising edge ignored, falling edge captured
        wr(A_RLD0, 32'h500);
        wr(A_CTL0, C_LOAD);
        wr(A_CTL0, C_CAPT | C_CPOL | C_RUN);
        cap_in[0] = 1'b1;
        ticks(6);
        rd(A_RLD0, v); chk("R7 wrong edge ignored", v, 32'h500);
        rd(A_CTL0, v); chk("R7 wrong edge no pending", {31'd0, v[7]}, 0);
        cap_in[0] = 1'b0;
        ticks(1);
        ticks(1);
        rd(A_CNT0, w);
        ticks(1);
        rd(A_RLD0, v); chk("R7 falling capture value", v, w);
        wr(A_CTL0, C_PEND); wr(A_CTL1, C_PEND);

        // R8 PWM: period 9+1, high 3+1, sampled over 30 cycles
        wr(A_RLD0, 32'd9); wr(A_RLD1, 32'd3);
        wr(A_CTL1, C_LOAD); wr(A_CTL0, C_LOAD);
        wr(A_CTL1, C_DOWN | C_ARLD);
        wr(A_CTL0, C_DOWN | C_ARLD | C_PWM | C_GO);
        chk("R8 high at start", {31'd0, pwm_out}, 1);
        hi = 0;
        for (int k = 0; k < 30; k++) begin
            if (k > 0) begin @(posedge clk); @(negedge clk); end
            hi += int'(pwm_out);
        end
        chk("R8 high cycles", hi, 12);
        wr(A_CTL0, C_PEND); wr(A_CTL1, C_PEND);
        chk("R8 low when unpaired", {31'd0, pwm_out}, 0);

        // R9 high time above period: stays high
        wr(A_RLD0, 32'd9); wr(A_RLD1, 32'd20);
        wr(A_CTL1, C_LOAD); wr(A_CTL0, C_LOAD);
        wr(A_CTL1, C_DOWN | C_ARLD);
        wr(A_CTL0, C_DOWN | C_ARLD | C_PWM | C_GO);
        hi = 0;
        for (int k = 0; k < 30; k++) begin
            if (k > 0) begin @(posedge clk); @(negedge clk); end
            hi += int'(pwm_out);
        end
        chk("R9 always high", hi, 30);
        wr(A_CTL0, C_PEND); wr(A_CTL1, C_PEND);

        // R11 start-both lockstep
        wr(A_RLD0, 32'h1000); wr(A_RLD1, 32'h2000);
        wr(A_CTL1, C_LOAD); wr(A_CTL0, C_LOAD);
        wr(A_CTL1, 0);
        wr(A_CTL0, C_GO);
        ticks(7);
        rd(A_CNT0, v); chk("R11 ch0 count", v, 32'h1007);
        rd(A_CNT1, v); chk("R11 ch1 count", v, 32'h2007);
        rd(A_CTL1, v); chk("R11 ch1 run set", {31'd0, v[6]}, 1);
        rd(A_CTL0, v); chk("R11 start bit reads zero", {31'd0, v[8]}, 0);
        wr(A_CTL0, C_PEND); wr(A_CTL1, C_PEND);

        // R10 chaining: lower carry steps upper
        wr(A_RLD0, 32'hFFFF_FFFE); wr(A_RLD1, 32'h5);
        wr(A_CTL1, C_LOAD); wr(A_CTL0, C_LOAD);
        wr(A_CTL1, 0);
        wr(A_CTL0, C_CASC | C_ARLD | C_IEN | C_GO);
        ticks(3);
        rd(A_CNT0, v); chk("R10 lower wrapped", v, 32'h1);
        rd(A_CNT1, v); chk("R10 upper stepped", v, 32'h6);
        rd(A_CTL0, v); chk("R10 no event on lower carry", {31'd0, v[7]}, 0);
        wr(A_CTL0, C_PEND); wr(A_CTL1, C_PEND);

        // R10 chaining: full 64-bit terminal reloads both halves
        wr(A_RLD0, 32'hFFFF_FFFE); wr(A_RLD1, 32'hFFFF_FFFF);
        wr(A_CTL1, C_LOAD); wr(A_CTL0, C_LOAD);
        wr(A_CTL1, 0);
        wr(A_CTL0, C_CASC | C_ARLD | C_IEN | C_GO);
        ticks(2);
        rd(A_CNT0, v); chk("R10 lower reloaded", v, 32'hFFFF_FFFE);
        rd(A_CNT1, v); chk("R10 upper reloaded", v, 32'hFFFF_FFFF);
        rd(A_CTL0, v); chk("R10 64-bit event pending", {31'd0, v[7]}, 1);
        chk("R10 irq", {31'd0, irq}, 1);
        wr(A_CTL0, C_PEND); wr(A_CTL1, C_PEND);

        finish_run();
    end
endmodule